// File: doc/BRIEF.md
# Random Level-1 Accept Generator

This block produces pseudo-random trigger-accept pulses for a beam-crossing timeline. A bunch pattern source upstream supplies, each clock, the current crossing number and a flag that says whether that crossing slot holds a filled bunch. On every slot where the block is enabled and the slot is filled, a 22-bit linear feedback shift register is compared with a programmable threshold. If the register value is below the threshold, an accept is issued. The threshold therefore sets the mean accept probability per filled slot, which is about threshold / (2^22 - 1). This lets the mean rate be tuned across a wide span, from a few hertz up to around 100 kHz.

Every accept is tagged with the crossing number of the slot that produced it and with a running event number. The tags are held on the outputs until the next accept, so a downstream record writer can capture them on the pulse. Trigger-rule throttling and backpressure are handled elsewhere.

Top module: `l1a_rand_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `l1a_o` is 0, `bxn_o` is 0 and `evn_o` is 0.
- R2: The random state is a 22-bit Fibonacci LFSR loaded with the seed (default 22'h000001) on reset. Each step shifts left, and bit 21 XOR bit 20 of the old value enters at bit 0. The state never becomes zero.
- R3: A slot is evaluated when `en_i` and `filled_i` are both 1 at a rising clock edge. At that edge the LFSR steps exactly once. When neither condition holds, the LFSR holds its value.
- R4: `l1a_o` is 1 in the cycle after an evaluated slot exactly when the LFSR value before the step is strictly less than `thr_i`, compared unsigned. Otherwise it is 0.
- R5: No accept follows a slot with `filled_i` = 0 or `en_i` = 0, whatever the threshold.
- R6: With `thr_i` = 0 no accept ever fires. With `thr_i` all ones, every evaluated slot fires except one whose LFSR value is all ones.
- R7: On an accept, `bxn_o` equals the `bxn_i` of the firing slot. `bxn_o` stays unchanged in every cycle without an accept.
- R8: The first accept after reset carries `evn_o` = 0. Each later accept carries the previous value plus one, wrapping at 2^EVN_W. `evn_o` is unchanged in cycles without an accept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables slot evaluation |
| thr_i | input | LFSR_W (22) | Accept threshold; larger values give a higher rate |
| bxn_i | input | BXN_W (12) | Crossing number of the current slot |
| filled_i | input | 1 | Current slot holds a filled bunch |
| l1a_o | output | 1 | Accept pulse, one cycle per firing slot |
| bxn_o | output | BXN_W (12) | Crossing number of the latest accept |
| evn_o | output | EVN_W (20) | Event number of the latest accept |

## Verification
A corrupted LFSR state, or one stepped on the wrong slots, shows at the ports within a few evaluated slots. The accept pattern for a mid-range threshold then departs from the bit-exact sequence the bench predicts. A stuck or skipped event counter appears on the next accept as a wrong `evn_o`. A mistake in the tag capture appears as a `bxn_o` that differs from the firing slot, or that drifts between accepts. Threshold extremes and empty or disabled slots expose an inverted or non-strict compare, or a missing filled gate, on the very next cycle.

// File: rtl/l1a_pkg.sv
package l1a_pkg;
  // Second feedback tap (0-based) for a maximal-length Fibonacci LFSR
  // whose first tap is the top bit.
  function automatic int lfsr_tap2(input int w);
    case (w)
      7:       return 5;
      15:      return 13;
      22:      return 20;
      23:      return 17;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/l1a_lfsr.sv
module l1a_lfsr #(
  parameter int          W    = 22,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  localparam int TAP2 = l1a_pkg::lfsr_tap2(W);

  logic [W-1:0] state_q;
  logic         fb;

  assign fb = state_q[W-1] ^ state_q[TAP2];

  always_ff @(posedge clk_i) begin
    if (rst_i)       state_q <= SEED;
    else if (step_i) state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/l1a_decide.sv
module l1a_decide #(
  parameter int W = 22
) (
  input  logic [W-1:0] rnd_i,
  input  logic [W-1:0] thr_i,
  input  logic         en_i,
  input  logic         filled_i,
  output logic         eval_o,
  output logic         fire_o
);
  always_comb begin
    eval_o = en_i & filled_i;
    fire_o = eval_o & (rnd_i < thr_i);
  end
endmodule

// File: rtl/l1a_tagger.sv
module l1a_tagger #(
  parameter int BXN_W = 12,
  parameter int EVN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             fire_i,
  input  logic [BXN_W-1:0] bxn_i,
  output logic             l1a_o,
  output logic [BXN_W-1:0] bxn_o,
  output logic [EVN_W-1:0] evn_o
);
  logic [EVN_W-1:0] next_evn_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      l1a_o      <= 1'b0;
      bxn_o      <= '0;
      evn_o      <= '0;
      next_evn_q <= '0;
    end else begin
      l1a_o <= fire_i;
      if (fire_i) begin
        bxn_o      <= bxn_i;
        evn_o      <= next_evn_q;
        next_evn_q <= next_evn_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/l1a_rand_gen.sv
module l1a_rand_gen #(
  parameter int              LFSR_W = 22,
  parameter int              BXN_W  = 12,
  parameter int              EVN_W  = 20,
  parameter logic [LFSR_W-1:0] SEED = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [LFSR_W-1:0] thr_i,
  input  logic [BXN_W-1:0]  bxn_i,
  input  logic              filled_i,
  output logic              l1a_o,
  output logic [BXN_W-1:0]  bxn_o,
  output logic [EVN_W-1:0]  evn_o
);
  logic [LFSR_W-1:0] rnd;
  logic              eval_slot;
  logic              fire;

  l1a_lfsr #(.W(LFSR_W), .SEED(SEED)) lfsr_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .step_i  (eval_slot),
    .state_o (rnd)
  );

  l1a_decide #(.W(LFSR_W)) decide_i (
    .rnd_i    (rnd),
    .thr_i    (thr_i),
    .en_i     (en_i),
    .filled_i (filled_i),
    .eval_o   (eval_slot),
    .fire_o   (fire)
  );

  l1a_tagger #(.BXN_W(BXN_W), .EVN_W(EVN_W)) tagger_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .fire_i (fire),
    .bxn_i  (bxn_i),
    .l1a_o  (l1a_o),
    .bxn_o  (bxn_o),
    .evn_o  (evn_o)
  );
endmodule

// File: rtl/l1a_rand_gen_chk.sv
module l1a_rand_gen_chk #(
  parameter int LFSR_W = 22,
  parameter int BXN_W  = 12,
  parameter int EVN_W  = 20
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              en_i,
  input logic [LFSR_W-1:0] thr_i,
  input logic              filled_i,
  input logic [LFSR_W-1:0] rnd,
  input logic              l1a_o,
  input logic [BXN_W-1:0]  bxn_o,
  input logic [EVN_W-1:0]  evn_o
);
  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rnd != '0);

  // R3
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(en_i && filled_i) |=> $stable(rnd));

  // R4
  below_thr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && filled_i && rnd < thr_i) |=> l1a_o);

  // R5
  gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(en_i && filled_i) |=> !l1a_o);

  // R7
  bxn_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !l1a_o |-> $stable(bxn_o));

  // R8
  evn_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !l1a_o |-> $stable(evn_o));

  // R8
  evn_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (l1a_o && $past(l1a_o)) |-> evn_o == EVN_W'($past(evn_o) + 1'b1));
endmodule

bind l1a_rand_gen l1a_rand_gen_chk #(
  .LFSR_W(LFSR_W), .BXN_W(BXN_W), .EVN_W(EVN_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .en_i     (en_i),
  .thr_i    (thr_i),
  .filled_i (filled_i),
  .rnd      (rnd),
  .l1a_o    (l1a_o),
  .bxn_o    (bxn_o),
  .evn_o    (evn_o)
);

// File: tb/l1a_rand_gen_tb_top.sv
module l1a_rand_gen_tb_top;
  localparam int LW = 22;
  localparam int BW = 12;
  localparam int EW = 4;

  logic          clk = 0;
  logic          rst = 1;
  logic          en = 0;
  logic          filled = 0;
  logic [LW-1:0] thr = '0;
  logic [BW-1:0] bxn = '0;
  logic          l1a;
  logic [BW-1:0] bxn_o;
  logic [EW-1:0] evn_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [LW-1:0] m_lfsr;
  logic [BW-1:0] m_bxn;
  logic [EW-1:0] m_evn_last;
  logic [EW-1:0] m_evn_next;
  int            bx_ctr = 0;

  always #10 clk = ~clk;

  l1a_rand_gen #(.LFSR_W(LW), .BXN_W(BW), .EVN_W(EW)) dut_i (
    .clk_i(clk), .rst_i(rst), .en_i(en), .thr_i(thr), .bxn_i(bxn),
    .filled_i(filled), .l1a_o(l1a), .bxn_o(bxn_o), .evn_o(evn_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one slot at a negedge, check outputs at the following negedge.
  task automatic slot(input bit e, input bit f, input logic [LW-1:0] t);
    logic fire;
    en = e; filled = f; thr = t; bxn = BW'(bx_ctr);
    fire = e && f && (m_lfsr < t);
    @(negedge clk);
    if (!(e && f)) chk("R5", {31'd0, l1a}, 32'd0);
    else           chk("R4", {31'd0, l1a}, {31'd0, fire});
    if (fire) begin
      m_bxn      = BW'(bx_ctr);
      m_evn_last = m_evn_next;
      m_evn_next = m_evn_next + 1'b1;
    end
    chk("R7", {20'd0, bxn_o}, {20'd0, m_bxn});
    chk("R8", {28'd0, evn_o}, {28'd0, m_evn_last});
    if (e && f) m_lfsr = {m_lfsr[LW-2:0], m_lfsr[LW-1] ^ m_lfsr[LW-2]}; // R2, R3
    bx_ctr = (bx_ctr == 3563) ? 0 : bx_ctr + 1;
  endtask

  task automatic run_train(input int n, input logic [LW-1:0] t, input int en_period);
    for (int i = 0; i < n; i++)
      slot((en_period == 0) || (i % en_period != 0), ((i % 80) < 72), t);
  endtask

  initial begin
    m_lfsr = 22'h000001; m_bxn = '0; m_evn_last = '0; m_evn_next = '0;
    repeat (3) @(negedge clk);
    chk("R1", {31'd0, l1a}, 32'd0);
    chk("R1", {20'd0, bxn_o}, 32'd0);
    chk("R1", {28'd0, evn_o}, 32'd0);
    rst = 0;
    @(negedge clk);
    chk("R1", {31'd0, l1a}, 32'd0);
    chk("R1", {28'd0, evn_o}, 32'd0);
    // R6: zero threshold never fires
    for (int i = 0; i < 300; i++) slot(1, 1, '0);
    // R6: all-ones threshold fires on nearly every filled slot
    run_train(400, '1, 0);
    // R5: high threshold, slots empty or disabled
    for (int i = 0; i < 200; i++) slot(i % 2, 0, '1);
    for (int i = 0; i < 200; i++) slot(0, 1, '1);
    // R3, R4: threshold sweep with enable gaps
    for (int k = 1; k <= 16; k++)
      run_train(500, LW'(k * 262144 - 1), (k % 3) + 2);
    // Low thresholds compared near the LFSR seed values
    for (int t = 1; t <= 40; t++) slot(1, 1, LW'(t));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule